// File: doc/BRIEF.md
# GPIO Port Controller with Change-Detect Interrupts

This block controls one eight-pin general-purpose I/O port. The CPU writes data, interrupt-enable, interrupt-mode, bypass-select and drive-mode registers through a simple write port. It samples the pins through a read strobe. Each pin's input passes through a two-stage synchroniser. The synchronised value is returned on the read data bus, and it feeds a per-pin interrupt detector.

Each pin can raise an interrupt in one of two modes. In level-low mode it requests for as long as its input is low. In change mode it compares its input against a snapshot taken at the CPU's most recent port read. A snapshot of 0 means a high input requests, and a snapshot of 1 means a low input requests. The snapshot changes only when the CPU reads the port. If software skips the read, the stale value stays in use. The per-pin requests are ORed together and gated by a port mask bit and a global interrupt enable. The result is one level-sensitive request line.

On the output side, each pin drives its CPU data bit unless bypass is selected. Bypass is selected either by an attached serial function claiming the pin or by a user bypass bit. When bypass is selected, an internal peripheral signal drives the pin. Two per-pin drive-mode bits are passed straight to the pad and do not depend on bypass.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset all registers are zero (data, enable, mode, user bypass, both drive-mode sets, port mask) and the read snapshot is all zeros. As a result, pin_out, drv_sel0, drv_sel1 and port_irq are 0.
- R2: A pin whose enable bit is 0 never contributes to port_irq, whatever its mode bit holds.
- R3: A pin with enable 1 and mode 0 requests while its synchronised input is low.
- R4: A pin with enable 1 and mode 1 requests while its synchronised input differs from its read snapshot. A snapshot of 0 means a high input requests, and a snapshot of 1 means a low input requests.
- R5: The snapshot loads the synchronised pin values at the clock edge where port_rd is 1. At every other edge it holds, so a request in change mode persists until a read.
- R6: port_irq is the OR of all pin requests ANDed with gie and the port mask bit. It is level-sensitive and combinational from gie.
- R7: With bypass off, pin_out[i] equals data register bit i. With bypass on, pin_out[i] equals periph_in[i].
- R8: Bypass for pin i is on when serial_en[i] is 1 or user bypass bit i is 1.
- R9: drv_sel0 and drv_sel1 equal their registers bit for bit, unaffected by bypass.
- R10: A pin change reaches port_rd_data and the interrupt detector after exactly two rising clock edges.
- R11: Register writes take effect at the edge where wr_en is 1. The addresses are 0 data, 1 enable, 2 mode, 3 user bypass, 4 drive-mode bit 0, 5 drive-mode bit 1, and 6 port mask (wr_data bit 0). A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Raw pad inputs |
| periph_in | input | 8 | Internal peripheral signals for the bypass path |
| serial_en | input | 8 | Per-pin claim by an attached serial function |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| port_rd | input | 1 | Port read strobe; loads the snapshot |
| port_rd_data | output | 8 | Synchronised pin values |
| pin_out | output | 8 | Pad output data |
| drv_sel0 | output | 8 | Drive-mode bit 0 per pin |
| drv_sel1 | output | 8 | Drive-mode bit 1 per pin |
| port_irq | output | 1 | Combined interrupt request |

## Verification
Two functions can meet in a single clock edge. The first is a port read that reloads the snapshot. The second is either a register write or a pin edge still moving through the synchroniser. The bench pulses port_rd in the same cycle that it writes the enable register on pins that already differ from the snapshot. port_irq must stay low, which shows that the comparison uses the freshly loaded snapshot. It also pulses port_rd in the same cycle that it toggles the pins. There it checks that the snapshot takes the old synchronised value, that port_irq is low after one edge, and that port_irq rises one edge later when the new value leaves the synchroniser.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_IE   = 3'd1,
        REG_MODE = 3'd2,
        REG_BYP  = 3'd3,
        REG_DRV0 = 3'd4,
        REG_DRV1 = 3'd5,
        REG_MASK = 3'd6,
        REG_NONE = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
    parameter int NPINS   = 8,
    parameter int NSTAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_sync
);

    localparam int LAST = NSTAGES - 1;

    logic [NPINS-1:0] stage_d [NSTAGES];
    logic [NPINS-1:0] stage_q [NSTAGES];

    always_comb begin
        stage_d[0] = pin_in;
        for (int s = 1; s < NSTAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign pin_sync = stage_q[LAST];

    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sync == $past(stage_q[LAST-1])); // R10

endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
    import gpio_chg_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  data_o,
    output logic [NPINS-1:0]  ie_o,
    output logic [NPINS-1:0]  mode_o,
    output logic [NPINS-1:0]  ubyp_o,
    output logic [NPINS-1:0]  drv0_o,
    output logic [NPINS-1:0]  drv1_o,
    output logic              mask_o
);

    typedef struct packed {
        logic [NPINS-1:0] data;
        logic [NPINS-1:0] ie;
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] ubyp;
        logic [NPINS-1:0] drv0;
        logic [NPINS-1:0] drv1;
        logic             mask;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                REG_DATA: regs_d.data = wr_data;
                REG_IE:   regs_d.ie   = wr_data;
                REG_MODE: regs_d.mode = wr_data;
                REG_BYP:  regs_d.ubyp = wr_data;
                REG_DRV0: regs_d.drv0 = wr_data;
                REG_DRV1: regs_d.drv1 = wr_data;
                REG_MASK: regs_d.mask = wr_data[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign data_o = regs_q.data;
    assign ie_o   = regs_q.ie;
    assign mode_o = regs_q.mode;
    assign ubyp_o = regs_q.ubyp;
    assign drv0_o = regs_q.drv0;
    assign drv1_o = regs_q.drv1;
    assign mask_o = regs_q.mask;

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_DATA) |=> (data_o == $past(wr_data))); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr == REG_NONE) |=> $stable(regs_q)); // R11

endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_sync,
    input  logic [NPINS-1:0] ie,
    input  logic [NPINS-1:0] mode,
    input  logic             rd_stb,
    output logic [NPINS-1:0] req_o
);

    logic [NPINS-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = rd_stb ? pin_sync : snap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            always_comb begin
                if (!ie[i])       req_o[i] = 1'b0;
                else if (mode[i]) req_o[i] = pin_sync[i] ^ snap_q[i];
                else              req_o[i] = ~pin_sync[i];
            end
        end
    endgenerate

    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (snap_q == $past(pin_sync))); // R5
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(snap_q)); // R5

endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int NPINS   = 8,
    parameter int NSTAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  periph_in,
    input  logic [NPINS-1:0]  serial_en,
    input  logic              gie,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic              port_rd,
    output logic [NPINS-1:0]  port_rd_data,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  drv_sel0,
    output logic [NPINS-1:0]  drv_sel1,
    output logic              port_irq
);

    logic [NPINS-1:0] sync_w, data_w, ie_w, mode_w, ubyp_w, req_w, byp_w;
    logic             mask_w;

    gpio_chg_sync #(.NPINS(NPINS), .NSTAGES(NSTAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (sync_w)
    );

    gpio_chg_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .data_o  (data_w),
        .ie_o    (ie_w),
        .mode_o  (mode_w),
        .ubyp_o  (ubyp_w),
        .drv0_o  (drv_sel0),
        .drv1_o  (drv_sel1),
        .mask_o  (mask_w)
    );

    gpio_chg_irq #(.NPINS(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (sync_w),
        .ie       (ie_w),
        .mode     (mode_w),
        .rd_stb   (port_rd),
        .req_o    (req_w)
    );

    assign byp_w = serial_en | ubyp_w;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_out
            assign pin_out[i] = byp_w[i] ? periph_in[i] : data_w[i];
        end
    endgenerate

    assign port_rd_data = sync_w;
    assign port_irq     = gie & mask_w & (|req_w);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        port_irq |-> (gie && mask_w)); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_w == '0) |-> !port_irq); // R2
    AST_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && mask_w && |(ie_w & ~mode_w & ~sync_w)) |-> port_irq); // R3

endmodule

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0, periph_in = '0, serial_en = '0, wr_data = '0;
    logic       gie = 1'b0, wr_en = 1'b0, port_rd = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] port_rd_data, pin_out, drv_sel0, drv_sel1;
    logic       port_irq;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    gpio_chg_port uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .periph_in(periph_in),
        .serial_en(serial_en), .gie(gie), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .port_rd(port_rd), .port_rd_data(port_rd_data),
        .pin_out(pin_out), .drv_sel0(drv_sel0), .drv_sel1(drv_sel1),
        .port_irq(port_irq)
    );

    // {ie, mode, snapshot, pin, expected request}
    localparam logic [4:0] VEC [16] = '{
        5'b0000_0, 5'b0001_0, 5'b0010_0, 5'b0011_0,
        5'b0100_0, 5'b0101_0, 5'b0110_0, 5'b0111_0,
        5'b1000_1, 5'b1001_0, 5'b1010_1, 5'b1011_0,
        5'b1100_0, 5'b1101_1, 5'b1110_1, 5'b1111_0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        port_rd = 1'b1;
        @(negedge clk);
        port_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_out", pin_out, 0);
        check("R1 drv", {drv_sel1, drv_sel0}, 0);
        check("R1 irq", port_irq, 0);
        gie = 1'b1;
        wr(3'd6, 8'h01);
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'hFF);
        @(negedge clk);
        check("R1 snapshot zero", port_irq, 0);
        // R10 two-edge synchroniser
        pin_in = 8'h5A;
        @(negedge clk);
        check("R10 one edge", port_rd_data, 8'h00);
        @(negedge clk);
        check("R10 two edges", port_rd_data, 8'h5A);
        check("R4 change vs zero snapshot", port_irq, 1);

        // Vector walk on pin 0
        for (int v = 0; v < 16; v++) begin
            logic [4:0] e;
            e = VEC[v];
            wr(3'd1, 8'h00);
            pin_in = {8{e[2]}};
            settle();
            wr(3'd2, {7'b0, e[3]});
            rd();
            wr(3'd1, {7'b0, e[4]});
            pin_in = {8{e[1]}};
            settle();
            check(e[4] == 1'b0 ? "R2 vector" : (e[3] ? "R4 vector" : "R3 vector"),
                  port_irq, e[0]);
        end

        // R5 stale snapshot persists, then a read clears
        wr(3'd1, 8'h00);
        pin_in = 8'h00; settle();
        rd();
        wr(3'd2, 8'hFF); wr(3'd1, 8'hFF);
        pin_in = 8'hFF; settle();
        repeat (5) @(negedge clk);
        check("R5 stale holds", port_irq, 1);
        rd();
        check("R5 read clears", port_irq, 0);
        pin_in = 8'h7F; settle();
        check("R4 low vs one snapshot", port_irq, 1);

        // R6 gating
        gie = 1'b0; #1;
        check("R6 gie off", port_irq, 0);
        gie = 1'b1;
        wr(3'd6, 8'h00);
        check("R6 mask off", port_irq, 0);
        wr(3'd6, 8'h01);
        check("R6 both on", port_irq, 1);

        // R7 R8 R9 output path
        wr(3'd0, 8'hA5); wr(3'd4, 8'h55); wr(3'd5, 8'h33);
        periph_in = 8'h3C;
        @(negedge clk);
        check("R7 data path", pin_out, 8'hA5);
        wr(3'd3, 8'h0F);
        check("R8 user bypass", pin_out, 8'hAC);
        check("R9 drv with bypass", {drv_sel1, drv_sel0}, 16'h3355);
        wr(3'd3, 8'h00);
        serial_en = 8'hF0; @(negedge clk);
        check("R8 serial bypass", pin_out, 8'h35);
        check("R9 drv with serial", {drv_sel1, drv_sel0}, 16'h3355);

        // R11 write to unused address has no effect
        wr(3'd7, 8'hFF);
        check("R11 unused pin_out", pin_out, 8'h35);
        check("R11 unused drv", {drv_sel1, drv_sel0}, 16'h3355);
        check("R11 unused irq", port_irq, 1);
        serial_en = 8'h00;

        // Same cycle: read and enable write
        wr(3'd1, 8'h00);
        pin_in = 8'h00; settle(); rd();
        pin_in = 8'hFF; settle();
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'hFF; port_rd = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; port_rd = 1'b0;
        check("R5 read with write", port_irq, 0);
        pin_in = 8'h00; settle();
        check("R4 after same-cycle read", port_irq, 1);

        // Same cycle: read and pin edge in the synchroniser
        port_rd = 1'b1; pin_in = 8'hFF;
        @(negedge clk);
        port_rd = 1'b0;
        check("R5 read takes old sync value", port_irq, 0);
        @(negedge clk);
        check("R10 new value after second edge", port_irq, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule